// File: doc/BRIEF.md
# Sixteen-Pin GPIO Bank with Per-Pin Interrupt Triggering

This block is one bank of general-purpose pins. A single 16-bit register port with plain read and write strobes controls it. Each pin has a direction bit, a drive value, an alternate-function select bit, an interrupt mask bit and three trigger bits. The bank runs every incoming pin level through a two-flop synchroniser and then checks each pin against its own trigger rule. That rule is a rising edge, a falling edge, an active-high level or an active-low level. When an unmasked pin's condition occurs, the bank latches a pending bit. The OR of all pending bits drives one interrupt line up to a top-level interrupt controller.

Software services the bank by reading the pending register and writing back a clearing pattern. Register access is a control path, so it has no valid/ready handshake. A write takes effect on the clock edge where `reg_wr` is high. Read data appears on `reg_rdata` one cycle after `reg_rd`. Pad drivers and the meaning of the alternate functions belong to logic outside this block. The bank only presents the output-enable, the drive value and the alternate-function select for each pin.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset the mask register (offset 4) reads 0xFFFF. The direction (1), drive (2), alternate (3), trigger-type (5), edge-polarity (6), level-polarity (7) and pending (8) registers read 0. `irq` and `pin_oe` are 0.
- R2: Writes to the direction (1), drive (2) and alternate (3) registers read back unchanged. `pin_oe` follows the direction bits, where 1 means output. `pin_out` follows the drive register and `alt_sel` follows the alternate register.
- R3: Offset 0 reads the synchronised pin levels. A change on `pin_in` is visible there no later than three clock edges after it is applied.
- R4: A pin whose mask bit is 1 never sets its pending bit, whatever happens on the pin.
- R5: With trigger-type 1 and edge-polarity 1, a low-to-high transition on an unmasked pin sets its pending bit. A high-to-low transition on that pin does not.
- R6: With trigger-type 1 and edge-polarity 0, a high-to-low transition sets the pending bit. A low-to-high transition does not.
- R7: With trigger-type 0, the pending bit is set on every cycle the synchronised level equals the level-polarity bit (1 means active high, 0 means active low). It therefore re-asserts after a clear for as long as the condition holds.
- R8: A write to the pending register (offset 8) keeps only the pending bits whose written bit is 1. Writing 0 clears them all.
- R9: If a detection occurs in the same cycle as a clearing write, the new pending bit stays set.
- R10: `irq` is 1 exactly when at least one pending bit is 1.
- R11: The direction bits, and so `pin_oe`, change only on a write to offset 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; data valid the next cycle |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| pin_in | input | 16 | Asynchronous pin levels from the pads |
| pin_out | output | 16 | Value driven on output pins |
| pin_oe | output | 16 | Per-pin output enable |
| alt_sel | output | 16 | Per-pin alternate-function select |
| irq | output | 1 | Summary interrupt, OR of pending bits |

## Verification
The assertions assume that `reg_wr` and `reg_addr` are valid on every sampled edge once reset is released. They also assume that `pin_in` is settled enough at the clock edge that the first synchroniser stage resolves to a clean 0 or 1. The bench drives every input on the falling clock edge, so each input holds steady across the rising edges that sample it. It changes pin levels only while the register port is idle, except in the one case where it deliberately times a clearing write against a detection.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    RA_LEVEL = 4'd0,
    RA_DIR   = 4'd1,
    RA_DOUT  = 4'd2,
    RA_ALT   = 4'd3,
    RA_MASK  = 4'd4,
    RA_TRIG  = 4'd5,
    RA_EPOL  = 4'd6,
    RA_LPOL  = 4'd7,
    RA_PEND  = 4'd8
  } reg_addr_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] edge_mode,
  input  logic [W-1:0] epol,
  input  logic [W-1:0] lpol,
  output logic [W-1:0] hit
);
  logic [W-1:0] prev;

  always_ff @(posedge clk) begin
    if (!rst_n) prev <= '0;
    else        prev <= lvl;
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic rise, fall, edge_hit, lvl_hit;
    assign rise     = lvl[i] & ~prev[i];
    assign fall     = ~lvl[i] & prev[i];
    assign edge_hit = epol[i] ? rise : fall;
    assign lvl_hit  = ~(lvl[i] ^ lpol[i]);
    assign hit[i]   = edge_mode[i] ? edge_hit : lvl_hit;
  end

  // R5 R6: an edge-mode detection needs a change of the synchronised level
  assert_edge_needs_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((hit & edge_mode) & ~(lvl ^ $past(lvl))) == '0);
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_bank_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  input  logic [W-1:0]      level,
  input  logic [W-1:0]      hit,
  output logic [W-1:0]      rdata,
  output logic [W-1:0]      dir,
  output logic [W-1:0]      dout,
  output logic [W-1:0]      alt,
  output logic [W-1:0]      mask,
  output logic [W-1:0]      trig,
  output logic [W-1:0]      epol,
  output logic [W-1:0]      lpol,
  output logic [W-1:0]      pend
);
  logic [W-1:0] set_v, keep_v, rmux;
  logic         wr_pend;

  assign set_v   = hit & ~mask;
  assign wr_pend = wr && (addr == RA_PEND);
  assign keep_v  = wr_pend ? (pend & wdata) : pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir  <= '0;
      dout <= '0;
      alt  <= '0;
      mask <= '1;
      trig <= '0;
      epol <= '0;
      lpol <= '0;
      pend <= '0;
    end else begin
      if (wr) begin
        case (addr)
          RA_DIR:  dir  <= wdata;
          RA_DOUT: dout <= wdata;
          RA_ALT:  alt  <= wdata;
          RA_MASK: mask <= wdata;
          RA_TRIG: trig <= wdata;
          RA_EPOL: epol <= wdata;
          RA_LPOL: lpol <= wdata;
          default: ;
        endcase
      end
      pend <= keep_v | set_v;
    end
  end

  always_comb begin
    case (addr)
      RA_LEVEL: rmux = level;
      RA_DIR:   rmux = dir;
      RA_DOUT:  rmux = dout;
      RA_ALT:   rmux = alt;
      RA_MASK:  rmux = mask;
      RA_TRIG:  rmux = trig;
      RA_EPOL:  rmux = epol;
      RA_LPOL:  rmux = lpol;
      RA_PEND:  rmux = pend;
      default:  rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  rdata <= '0;
    else if (rd) rdata <= rmux;
  end

  // R4: a pending bit never rises while its mask bit was set
  assert_masked_no_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & ~$past(pend)) & $past(mask)) == '0);

  // R8: a clearing write with no detection leaves only the kept bits
  assert_clear_applies_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == RA_PEND && (hit & ~mask) == '0) |=> (pend & ~$past(wdata)) == '0);

  // R9: a detection during a clearing write survives
  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == RA_PEND) |=> (($past(hit) & ~$past(mask)) & ~pend) == '0);
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int NPIN        = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [NPIN-1:0]   reg_wdata,
  output logic [NPIN-1:0]   reg_rdata,
  input  logic [NPIN-1:0]   pin_in,
  output logic [NPIN-1:0]   pin_out,
  output logic [NPIN-1:0]   pin_oe,
  output logic [NPIN-1:0]   alt_sel,
  output logic              irq
);
  logic [NPIN-1:0] lvl_s, hit;
  logic [NPIN-1:0] dir, dout, alt, mask, trig, epol, lpol, pend;

  gpio_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(lvl_s)
  );

  gpio_trig_detect #(.W(NPIN)) u_det (
    .clk(clk), .rst_n(rst_n), .lvl(lvl_s), .edge_mode(trig),
    .epol(epol), .lpol(lpol), .hit(hit)
  );

  gpio_regfile #(.W(NPIN)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .level(lvl_s), .hit(hit), .rdata(reg_rdata),
    .dir(dir), .dout(dout), .alt(alt), .mask(mask), .trig(trig),
    .epol(epol), .lpol(lpol), .pend(pend)
  );

  assign pin_oe  = dir;
  assign pin_out = dout;
  assign alt_sel = alt;
  assign irq     = |pend;

  // R10: the summary line only rises after an unmasked detection
  assert_irq_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past((hit & ~mask) != '0));

  // R11: output enables move only on a direction write
  assert_oe_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == RA_DIR) |=> $stable(pin_oe));
endmodule

// File: tb/sim_gpio_irq_bank.sv
`timescale 1ns/1ps
module sim_gpio_irq_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic [15:0] pin_in = '0, pin_out, pin_oe, alt_sel;
  logic        irq;
  logic [15:0] rv;
  int          n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  gpio_irq_bank u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .alt_sel(alt_sel), .irq(irq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rreg(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic drive_pins(input logic [15:0] v);
    @(negedge clk); pin_in = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    rreg(4'd4, rv); check("R1 mask", rv, 16'hFFFF);
    rreg(4'd1, rv); check("R1 dir", rv, 16'h0000);
    rreg(4'd8, rv); check("R1 pend", rv, 16'h0000);
    check("R1 irq", {15'd0, irq}, 16'h0000);
    check("R1 oe", pin_oe, 16'h0000);
  endtask

  task automatic t_drive;
    wreg(4'd1, 16'hA5A5); wreg(4'd2, 16'h1234); wreg(4'd3, 16'h0F0F);
    check("R2 oe", pin_oe, 16'hA5A5);
    check("R2 out", pin_out, 16'h1234);
    check("R2 alt", alt_sel, 16'h0F0F);
    rreg(4'd2, rv); check("R2 dout rd", rv, 16'h1234);
    rreg(4'd3, rv); check("R2 alt rd", rv, 16'h0F0F);
    wreg(4'd2, 16'h0000);
    check("R11 oe held", pin_oe, 16'hA5A5);
  endtask

  task automatic t_level_read;
    drive_pins(16'h0E40);
    rreg(4'd0, rv); check("R3 level", rv, 16'h0E40);
    drive_pins(16'h0000);
    rreg(4'd0, rv); check("R3 level zero", rv, 16'h0000);
  endtask

  task automatic t_masked;
    wreg(4'd5, 16'h0028); wreg(4'd6, 16'h0008); wreg(4'd7, 16'h0080);
    drive_pins(16'h0008);
    rreg(4'd8, rv); check("R4 masked pend", rv, 16'h0000);
    check("R4 masked irq", {15'd0, irq}, 16'h0000);
    drive_pins(16'h0000);
  endtask

  task automatic t_rise;
    wreg(4'd4, 16'hFFF7);
    drive_pins(16'h0008);
    rreg(4'd8, rv); check("R5 rise pend", rv, 16'h0008);
    check("R10 irq high", {15'd0, irq}, 16'h0001);
    wreg(4'd8, 16'h0000);
    rreg(4'd8, rv); check("R8 clear", rv, 16'h0000);
    check("R10 irq low", {15'd0, irq}, 16'h0000);
    drive_pins(16'h0000);
    rreg(4'd8, rv); check("R5 fall ignored", rv, 16'h0000);
  endtask

  task automatic t_fall;
    wreg(4'd4, 16'hFFD7);
    drive_pins(16'h0020);
    rreg(4'd8, rv); check("R6 rise ignored", rv, 16'h0000);
    drive_pins(16'h0000);
    rreg(4'd8, rv); check("R6 fall pend", rv, 16'h0020);
  endtask

  task automatic t_set_wins;
    @(negedge clk); pin_in = 16'h0008;
    repeat (2) @(negedge clk);
    reg_wr = 1'b1; reg_addr = 4'd8; reg_wdata = 16'h0000;
    @(negedge clk); reg_wr = 1'b0;
    rreg(4'd8, rv); check("R9 set wins", rv, 16'h0008);
    drive_pins(16'h0000);
  endtask

  task automatic t_partial;
    drive_pins(16'h0020);
    drive_pins(16'h0000);
    rreg(4'd8, rv); check("R6 second fall", rv, 16'h0028);
    wreg(4'd8, 16'hFFF7);
    rreg(4'd8, rv); check("R8 partial", rv, 16'h0020);
    wreg(4'd8, 16'h0000);
  endtask

  task automatic t_level_irq;
    wreg(4'd4, 16'hFF57);
    rreg(4'd8, rv); check("R7 idle", rv, 16'h0000);
    drive_pins(16'h0080);
    rreg(4'd8, rv); check("R7 high pend", rv, 16'h0080);
    wreg(4'd8, 16'h0000);
    rreg(4'd8, rv); check("R7 reassert", rv, 16'h0080);
    drive_pins(16'h0000);
    wreg(4'd8, 16'h0000);
    rreg(4'd8, rv); check("R7 cleared", rv, 16'h0000);
    wreg(4'd7, 16'h0000);
    @(negedge clk);
    check("R7 active low irq", {15'd0, irq}, 16'h0001);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_drive;
    t_level_read;
    t_masked;
    t_rise;
    t_fall;
    t_set_wins;
    t_partial;
    t_level_irq;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule